// File: doc/BRIEF.md
# Gated Cyclic Syndrome Calculator

This block computes the syndrome of a word received under a binary (n,k) cyclic code. It holds an (n-k)-stage feedback shift register that divides the received polynomial by the generator polynomial g(X). A start pulse clears the register and the error flag and opens the input gate. The next n accepted bits enter serially, and the register then holds the remainder of r(X) modulo g(X). The input gate then closes and the output gate opens, and the remainder leaves one bit per cycle. During this unload phase zeros replace the feedback, so the register is empty when the unload ends.

A sticky set/reset flag records whether any unloaded remainder bit was one. A zero remainder marks a valid codeword, and a nonzero remainder marks a transmission error. Error correction is handled elsewhere. The code length, message length and generator polynomial are parameters. The defaults are n=7, k=4 and g(X)=1+X+X^3. `GPOLY` holds the coefficients of X^0 through X^(n-k-1), and the leading coefficient is implied.

Top module: `cyc_syndrome_calc`

## Requirements
- R1: After reset, `synd_valid_o`, `synd_bit_o`, `done_o` and `err_o` are all 0, and no word is being received.
- R2: A `start_i` pulse clears the remainder and `err_o` (low from the next cycle) and begins a new word. A start that arrives while a word is being received abandons that word, and a `bit_i` presented in the same cycle as `start_i` is not taken.
- R3: During reception a bit is accepted only in cycles where `bit_valid_i` is 1. Cycles with `bit_valid_i` at 0 change nothing. The first accepted bit is the coefficient of X^(n-1) and the n-th accepted bit is the coefficient of X^0.
- R4: Starting in the cycle after the edge that accepts the n-th bit, `synd_valid_o` is 1 for exactly n-k cycles. In those cycles `synd_bit_o` gives the remainder r(X) mod g(X), the coefficient of X^(n-k-1) first and X^0 last.
- R5: The input and output gates are never open together. `bit_valid_i` and `bit_i` have no effect while the syndrome is being unloaded or while the block is idle after an unload.
- R6: `done_o` is 1 only in the cycle that carries the last (X^0) syndrome bit. `synd_valid_o` is 0 in the cycle after it.
- R7: From the cycle after `done_o`, `err_o` is 1 exactly when the remainder was nonzero. It stays at that value until the next `start_i`.
- R8: An error-free word (a multiple of g(X)) yields an all-zero syndrome. A single flipped bit at position i yields X^i mod g(X).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clears the remainder and flag and opens the input gate |
| bit_valid_i | input | 1 | Qualifies `bit_i` |
| bit_i | input | 1 | Received bit, highest-order coefficient first |
| synd_bit_o | output | 1 | Serial syndrome bit, highest stage first |
| synd_valid_o | output | 1 | High while the output gate is open |
| done_o | output | 1 | Marks the last syndrome bit |
| err_o | output | 1 | Sticky flag for a nonzero syndrome |

## Verification
Codewords built by multiplying random messages by g(X) must give a zero syndrome and leave the flag low. Flipping each of the n positions in turn tells the remainder bits apart and catches a reversed bit order or a wrong feedback tap. Random double errors cover sums of single-error remainders, including pairs whose syndrome is nonzero but differs from both single-error ones. Stalls in the valid strobe, junk bits sent while unloading or idle, an aborted word and a restart after a flagged word separate the gating and clearing behaviour from the division itself.

// File: rtl/cyc_syndrome_calc.sv
module cyc_syndrome_calc #(
  parameter int N = 7,
  parameter int K = 4,
  parameter logic [N-K-1:0] GPOLY = 3'b011
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic bit_valid_i,
  input  logic bit_i,
  output logic synd_bit_o,
  output logic synd_valid_o,
  output logic done_o,
  output logic err_o
);
  localparam int M  = N - K;
  localparam int CW = $clog2(N);

  typedef enum logic [1:0] {PH_IDLE, PH_RECV, PH_UNLD} phase_t;

  phase_t        phase;
  logic [M-1:0]  rem;
  logic [CW-1:0] cnt;
  logic          err_q;

  wire in_gate  = (phase == PH_RECV);
  wire out_gate = (phase == PH_UNLD);
  wire last_in  = (cnt == CW'(N-1));
  wire last_out = (cnt == CW'(M-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      rem   <= '0;
      cnt   <= '0;
      err_q <= 1'b0;
    end else if (start_i) begin
      phase <= PH_RECV;
      rem   <= '0;
      cnt   <= '0;
      err_q <= 1'b0;
    end else begin
      case (phase)
        PH_RECV: if (bit_valid_i) begin
          rem <= {rem[M-2:0], bit_i} ^ (rem[M-1] ? GPOLY : '0);
          if (last_in) begin
            cnt   <= '0;
            phase <= PH_UNLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_UNLD: begin
          rem <= {rem[M-2:0], 1'b0};
          if (rem[M-1]) err_q <= 1'b1;
          if (last_out) begin
            cnt   <= '0;
            phase <= PH_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign synd_valid_o = out_gate;
  assign synd_bit_o   = out_gate & rem[M-1];
  assign done_o       = out_gate & last_out;
  assign err_o        = err_q;

  wire unused_ok = in_gate;
endmodule

// File: rtl/cyc_syndrome_calc_chk.sv
module cyc_syndrome_calc_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic synd_bit_o,
  input logic synd_valid_o,
  input logic done_o,
  input logic err_o
);
  // R6
  done_in_unload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> synd_valid_o);

  // R6
  unload_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> !synd_valid_o);

  // R4
  unload_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    synd_valid_o && !done_o && !start_i |=> synd_valid_o);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o && !start_i |=> err_o);

  // R7
  err_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    synd_valid_o && synd_bit_o && !start_i |=> err_o);

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !err_o && !synd_valid_o);

  // R1
  always_comb
    if (!rst_n) reset_quiet_chk: assert (!synd_valid_o && !done_o && !err_o);
endmodule

bind cyc_syndrome_calc cyc_syndrome_calc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .synd_bit_o(synd_bit_o),
  .synd_valid_o(synd_valid_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/cyc_syndrome_calc_tb.sv
module cyc_syndrome_calc_tb;
  localparam int N = 7;
  localparam int K = 4;
  localparam int M = N - K;
  localparam logic [M:0] GFULL = 4'b1011;

  logic clk = 0, rst_n = 0, start_i = 0, bit_valid_i = 0, bit_i = 0;
  logic synd_bit_o, synd_valid_o, done_o, err_o;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cyc_syndrome_calc #(.N(N), .K(K), .GPOLY(GFULL[M-1:0])) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_valid_i(bit_valid_i),
    .bit_i(bit_i), .synd_bit_o(synd_bit_o), .synd_valid_o(synd_valid_o),
    .done_o(done_o), .err_o(err_o));

  function automatic logic [M-1:0] modg(input logic [N-1:0] r);
    logic [N-1:0] t = r;
    for (int i = N-1; i >= M; i--)
      if (t[i]) t = t ^ (N'(GFULL) << (i-M));
    return t[M-1:0];
  endfunction

  function automatic logic [N-1:0] mulg(input logic [K-1:0] u);
    logic [N-1:0] c = '0;
    for (int i = 0; i < K; i++)
      if (u[i]) c = c ^ (N'(GFULL) << i);
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
  endtask

  // sends a word after a start; gap = idle cycles between bits, junk = noise while unloading
  task automatic run_word(input logic [N-1:0] r, input int gap, input bit junk, input string tag);
    logic [M-1:0] exp_s = modg(r);
    logic [M-1:0] got = '0;
    pulse_start();
    for (int i = N-1; i >= 0; i--) begin
      bit_valid_i = 1; bit_i = r[i];
      @(negedge clk);
      if (i > 0)
        for (int g = 0; g < gap; g++) begin
          bit_valid_i = 0; bit_i = ~bit_i;   // R3 stall cycles ignored
          @(negedge clk);
        end
    end
    bit_valid_i = junk; bit_i = junk;
    for (int j = 0; j < M; j++) begin
      chk(synd_valid_o === 1'b1, {"R4 valid ", tag}, synd_valid_o, 1);
      chk(done_o === (j == M-1), {"R6 done ", tag}, done_o, j == M-1);
      got = {got[M-2:0], synd_bit_o};
      if (junk) bit_i = $urandom_range(1);   // R5 gate closed
      @(negedge clk);
    end
    bit_valid_i = 0; bit_i = 0;
    chk(got === exp_s, {"R4 syndrome ", tag}, got, exp_s);
    chk(synd_valid_o === 1'b0, {"R6 end ", tag}, synd_valid_o, 0);
    chk(err_o === (exp_s != 0), {"R7 err ", tag}, err_o, exp_s != 0);
  endtask

  task automatic t_reset();
    #1;
    chk(!synd_valid_o && !done_o && !err_o && !synd_bit_o, "R1 reset", {synd_valid_o, done_o, err_o}, 0);
    @(negedge clk); rst_n = 1;
    bit_valid_i = 1; bit_i = 1;
    repeat (N+2) @(negedge clk);
    bit_valid_i = 0;
    chk(!synd_valid_o && !err_o, "R1 idle", synd_valid_o, 0);
  endtask

  task automatic t_clean();
    for (int n = 0; n < 6; n++) begin
      logic [N-1:0] c = mulg(K'($urandom));
      run_word(c, 0, 0, "R8 clean");
      chk(modg(c) == 0, "R8 ref", modg(c), 0);
    end
  endtask

  task automatic t_single();
    logic [N-1:0] c = mulg(K'($urandom));
    for (int p = 0; p < N; p++) begin
      logic [N-1:0] one = N'(1) << p;
      run_word(c ^ one, 0, 0, "R8 single");
    end
  endtask

  task automatic t_double();
    for (int n = 0; n < 8; n++) begin
      int a = $urandom_range(N-1);
      int b = (a + 1 + $urandom_range(N-2)) % N;
      logic [N-1:0] e = (N'(1) << a) | (N'(1) << b);
      run_word(mulg(K'($urandom)) ^ e, 0, 0, "double");
    end
  endtask

  task automatic t_stall();
    run_word(7'b1010011, 1, 0, "R3 stall1");
    run_word(7'b0110100, 3, 0, "R3 stall3");
  endtask

  task automatic t_gate();
    run_word(7'b1100101, 0, 1, "R5 junk");
    bit_valid_i = 1; bit_i = 1;
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      chk(synd_valid_o === 1'b0, "R5 idle gate", synd_valid_o, 0);
    end
    bit_valid_i = 0; bit_i = 0;
  endtask

  task automatic t_restart();
    logic [N-1:0] r = 7'b0000001;
    pulse_start();
    bit_valid_i = 1; bit_i = 1;
    repeat (3) @(negedge clk);
    bit_valid_i = 0;
    run_word(r, 0, 0, "R2 restart");
    chk(err_o === 1'b1, "R7 hold", err_o, 1);
    repeat (3) @(negedge clk);
    chk(err_o === 1'b1, "R7 sticky", err_o, 1);
    @(negedge clk); start_i = 1; bit_valid_i = 1; bit_i = 1;
    @(negedge clk); start_i = 0; bit_valid_i = 0;
    chk(err_o === 1'b0, "R2 clear", err_o, 1'b0);
    run_word(mulg(4'b1001), 0, 0, "R2 after clear");
  endtask

  initial begin
    t_reset();
    t_clean();
    t_single();
    t_double();
    t_stall();
    t_gate();
    t_restart();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule